// File: doc/BRIEF.md
# Scanline interrupt down-counter

This block raises a level interrupt request to the CPU after a programmed number of rendered video lines. Four decoded register write strobes share one 8-bit data bus: one loads the down-counter directly, one loads the reload latch, one disables counting and drops any pending request, and one enables counting. Address decoding happens upstream, and so does the generation of the once-per-line pulse. That pulse arrives with the current line number and a flag that says whether rendering is on.

A line pulse is counted only when its line number lies in the visible range (0 to 239), rendering is on, and counting is enabled. On a counted line the block first tests the counter's old value. If it was zero, the counter reloads from the latch and the request becomes pending. Otherwise the counter decrements. The request stays asserted until the disable strobe is written. Because the test comes before the decrement, a latch value N gives one request every N+1 counted lines once the counter has reloaded.

Top module: `line_irq_counter`

## Requirements
- R1: After reset, irq_o is 0 and the counter, the latch and the enable flag are all 0. An enable write followed by one counted line therefore asserts irq_o, and every further counted line reloads 0.
- R2: A pulse on cnt_wr_i loads wr_data_i directly into the counter. A counter value C asserts irq_o on the (C+1)-th counted line.
- R3: A pulse on latch_wr_i loads wr_data_i into the reload latch without changing the counter.
- R4: A pulse on irq_off_wr_i clears the enable flag and deasserts irq_o at the next clock edge.
- R5: A pulse on irq_on_wr_i sets the enable flag and changes neither the counter nor the state of irq_o.
- R6: A line pulse is counted only when line_num_i <= 239, render_en_i is 1, and the enable flag is set. Any other line pulse leaves the counter unchanged.
- R7: On a counted line with a nonzero counter, the counter decrements by one and irq_o does not change.
- R8: On a counted line with a zero counter, the counter reloads from the latch and irq_o becomes 1 at the next clock edge.
- R9: Once asserted, irq_o stays 1 through any line pulses and enable writes until an irq_off_wr_i pulse arrives.
- R10: If any write strobe is high in the same cycle as line_tick_i, the write takes effect and that line pulse is not counted.
- R11: With latch value N loaded, consecutive requests are N+1 counted lines apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 1 | Strobe: load the counter from wr_data_i |
| latch_wr_i | input | 1 | Strobe: load the reload latch from wr_data_i |
| irq_off_wr_i | input | 1 | Strobe: disable counting and clear the request |
| irq_on_wr_i | input | 1 | Strobe: enable counting |
| wr_data_i | input | 8 | Write data byte |
| line_tick_i | input | 1 | One-cycle pulse, once per video line |
| line_num_i | input | 9 | Line number that goes with line_tick_i |
| render_en_i | input | 1 | Rendering enabled |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The assertions assume that at most one write strobe is high in any cycle. This is how the upstream address decoder behaves, and it is what lets the counter-side properties treat a load and a step as mutually exclusive. The bench drives every strobe and line pulse for exactly one cycle, never raises two strobes together, and mixes a strobe with a line pulse only in the same-cycle priority scenario. The counter is not visible at the ports, so its value is inferred from the exact counted line on which irq_o rises after a known load.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  typedef struct packed {
    logic load_cnt;
    logic load_latch;
    logic irq_off;
    logic irq_on;
  } wr_evt_t;
endpackage

// File: rtl/lirq_gate.sv
module lirq_gate
  import lirq_pkg::*;
#(
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_evt_t           evt_i,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  output logic              step_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_LINE);

  logic en_q;
  logic any_wr;
  logic visible;

  assign any_wr  = |evt_i;
  assign visible = (line_i <= LastLine);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b0;
    else if (evt_i.irq_off) en_q <= 1'b0;
    else if (evt_i.irq_on)  en_q <= 1'b1;
  end

  // register traffic takes priority over the line pulse
  assign step_o = tick_i && render_i && en_q && visible && !any_wr;

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_i.load_cnt, evt_i.load_latch, evt_i.irq_off, evt_i.irq_on}));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |-> !step_o);
  assert_off_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.irq_off |=> !step_o);
  assert_gate_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (line_i <= LastLine) && render_i);
endmodule

// File: rtl/lirq_count.sv
module lirq_count #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_cnt_i,
  input  logic              load_latch_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              step_i,
  output logic              wrap_o
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] latch_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);
  assign wrap_o  = step_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           latch_q <= '0;
    else if (load_latch_i) latch_q <= data_i;
  end

  // test old value, then reload or decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_cnt_i) cnt_q <= data_i;
    else if (step_i)     cnt_q <= at_zero ? latch_q : cnt_q - 1'b1;
  end

  assert_load_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_cnt_i |=> cnt_q == $past(data_i));
  assert_load_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_latch_i |=> latch_q == $past(data_i));
  assert_decrement_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_cnt_i && !at_zero |=> cnt_q == DATA_W'($past(cnt_q) - 1'b1));
  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_cnt_i && !load_latch_i && at_zero |=> cnt_q == $past(latch_q));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_cnt_i |=> $stable(cnt_q));
endmodule

// File: rtl/lirq_flag.sv
module lirq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_q);
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_i |=> irq_q);
  assert_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(set_i));
endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter
  import lirq_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic              latch_wr_i,
  input  logic              irq_off_wr_i,
  input  logic              irq_on_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_tick_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  wr_evt_t evt;
  logic    step;
  logic    wrap;

  assign evt = '{load_cnt: cnt_wr_i, load_latch: latch_wr_i,
                 irq_off: irq_off_wr_i, irq_on: irq_on_wr_i};

  lirq_gate #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .tick_i  (line_tick_i),
    .line_i  (line_num_i),
    .render_i(render_en_i),
    .step_o  (step)
  );

  lirq_count #(.DATA_W(DATA_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_cnt_i  (cnt_wr_i),
    .load_latch_i(latch_wr_i),
    .data_i      (wr_data_i),
    .step_i      (step),
    .wrap_o      (wrap)
  );

  lirq_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wrap),
    .clr_i (irq_off_wr_i),
    .irq_o (irq_o)
  );

  assert_on_keeps_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_on_wr_i |=> irq_o == $past(irq_o));
endmodule

// File: tb/tb_line_irq_counter.sv
module tb_line_irq_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_wr = 1'b0, latch_wr = 1'b0, off_wr = 1'b0, on_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick = 1'b0;
  logic [8:0] line_num = '0;
  logic       render = 1'b1;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  line_irq_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .latch_wr_i(latch_wr),
    .irq_off_wr_i(off_wr), .irq_on_wr_i(on_wr), .wr_data_i(wdata),
    .line_tick_i(tick), .line_num_i(line_num), .render_en_i(render), .irq_o(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_o actual %b expected %b", req, act, exp);
    end
  endtask

  // one-cycle stimulus, returns at the next falling edge
  task automatic drive(input logic c, input logic l, input logic f, input logic o,
                       input logic [7:0] d, input logic t, input logic [8:0] ln,
                       input logic rd);
    @(negedge clk);
    cnt_wr = c; latch_wr = l; off_wr = f; on_wr = o; wdata = d;
    tick = t; line_num = ln; render = rd;
    @(negedge clk);
    cnt_wr = 0; latch_wr = 0; off_wr = 0; on_wr = 0; tick = 0;
  endtask

  task automatic wr_cnt(input logic [7:0] d); drive(1, 0, 0, 0, d, 0, 0, 1); endtask
  task automatic wr_lat(input logic [7:0] d); drive(0, 1, 0, 0, d, 0, 0, 1); endtask
  task automatic irq_off(); drive(0, 0, 1, 0, 0, 0, 0, 1); endtask
  task automatic irq_on(); drive(0, 0, 0, 1, 0, 0, 0, 1); endtask
  task automatic line(input logic [8:0] ln, input logic rd); drive(0, 0, 0, 0, 0, 1, ln, rd); endtask
  task automatic lines(input int n);
    for (int i = 0; i < n; i++) line(9'(20 + i), 1);
  endtask

  task automatic t_reset();
    check("R1 reset irq low", irq, 0);
    irq_on();
    line(5, 1);
    check("R1 zero counter fires on first line", irq, 1);
    irq_off();
    check("R4 off clears irq", irq, 0);
    irq_on();
    line(6, 1);
    check("R1 zero latch reloads zero", irq, 1);
    irq_off();
  endtask

  task automatic t_load_and_period();
    wr_lat(8'd5);
    wr_cnt(8'd3);
    irq_on();
    lines(3);
    check("R7 decrement without irq", irq, 0);
    line(30, 1);
    check("R2 counter 3 fires on 4th line", irq, 1);
    check("R8 irq on zero pass", irq, 1);
    irq_off();
    irq_on();
    lines(5);
    check("R3 latch 5 no irq after 5 lines", irq, 0);
    line(40, 1);
    check("R11 period N+1", irq, 1);
    irq_off();
  endtask

  task automatic t_gate();
    wr_lat(8'd200);
    wr_cnt(8'd1);
    irq_on();
    line(240, 1);
    line(300, 1);
    line(10, 0);
    irq_off();
    line(11, 1);
    irq_on();
    line(0, 1);
    check("R6 ungated pulses not counted", irq, 0);
    line(239, 1);
    check("R6 line 239 counts", irq, 1);
  endtask

  task automatic t_sticky();
    irq_on();
    check("R5 enable keeps irq", irq, 1);
    line(10, 0);
    line(250, 1);
    lines(3);
    check("R9 irq held through lines", irq, 1);
    irq_off();
    check("R4 off releases irq", irq, 0);
  endtask

  task automatic t_enable_keeps_cnt();
    wr_cnt(8'd2);
    irq_on();
    line(12, 1);
    irq_on();
    line(13, 1);
    check("R5 enable write leaves counter", irq, 0);
    line(14, 1);
    check("R5 counter continues after enable", irq, 1);
    irq_off();
  endtask

  task automatic t_race();
    wr_cnt(8'd0);
    irq_on();
    drive(1, 0, 0, 0, 8'd2, 1, 9'd10, 1);
    check("R10 counter write beats line", irq, 0);
    lines(2);
    check("R10 written value counts down", irq, 0);
    line(50, 1);
    check("R10 fires after written value", irq, 1);
    irq_off();
    wr_cnt(8'd0);
    irq_on();
    drive(0, 1, 0, 0, 8'd7, 1, 9'd10, 1);
    check("R10 latch write suppresses line", irq, 0);
    line(60, 1);
    check("R10 next line counts", irq, 1);
    irq_off();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_period();
    t_gate();
    t_sticky();
    t_enable_keeps_cnt();
    t_race();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule